// File: doc/BRIEF.md
# Synchronous Burst SRAM Bank

This block is one bank of a flow-through synchronous burst SRAM. The word is 72 bits wide and is split into eight byte lanes. Each lane carries eight data bits and one parity bit. The control inputs are sampled on every rising clock edge:

- a processor address strobe and a controller address strobe;
- an advance input;
- a bank enable;
- a global write;
- a byte-write mode enable;
- eight per-lane byte enables.

From these the bank starts, continues, suspends or cancels a burst. It also works out which byte lanes a write stores.

Read data comes straight from a small internal storage array. It is addressed by the address held in the register, with no output pipeline stage. The output drivers are enabled only while the current cycle is a read and the asynchronous output enable is low. Write data is taken from the input bus on the same edge that supplies the address.

A host can use the bank in two ways. In burst mode, one strobe is followed by advance cycles that step the two low address bits. In synchronous-only mode, the controller strobe is held low and the other two inputs are held high, so each edge is a single access at a new address.

Top module: `sbsram_bank`

## Requirements
- R1: With global write low, a write cycle stores all 72 bits, whatever the byte-write mode enable and the byte enables are.
- R2: With global write high, byte lane k is stored only when the byte-write mode enable is low and byte enable bit k is low. Lane k is data bits 8k..8k+7 plus parity bit 64+k of the 72-bit word. If no lane is selected, the cycle is a read.
- R3: A low processor strobe while the bank enable is low registers the input address and starts a read, even when the write inputs request a write.
- R4: A low controller strobe while the bank enable is low registers the input address and starts a read or a write, as the write controls decide. This applies when the processor strobe does not start a read on that edge.
- R5: A low controller strobe while the bank enable is high deselects the bank. The bus is released, any burst is cancelled, and later advance cycles neither write nor drive until a new strobe arrives.
- R6: With both strobes high during a burst, a low advance moves to the next address. The two low address bits count up modulo 4 and the upper bits are kept. The cycle can be a read or a write.
- R7: With both strobes high during a burst, a high advance keeps the current address. The cycle can be a read or a write.
- R8: Read data for an address registered on a rising edge is valid on the output in the same cycle, before the next edge.
- R9: The output is driven only in a read cycle while the active-low output enable is low. That enable acts asynchronously, with no clock edge needed.
- R10: The output is not driven in a write cycle.
- R11: After synchronous active-low reset, no burst is active and the output is not driven.
- R12: With the controller strobe held low and the processor strobe and advance held high, every edge is a single access at the newly presented address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all controls are sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address, registered by a strobe |
| proc_strobe_n | input | 1 | Processor address strobe, active low, read only |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Low: step the burst address; high: hold it |
| bank_en_n | input | 1 | Bank enable, active low, sampled with the strobes |
| gwrite_n | input | 1 | Global write, active low, writes all lanes |
| bwmode_n | input | 1 | Byte-write mode enable, active low |
| lane_we_n | input | LANES | Per-lane byte enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | WORD_W | Write word: data in bits 63:0, lane parity in 71:64 |
| rdata | output | WORD_W | Read word, same layout |
| rdata_drive | output | 1 | High when rdata should be driven onto the bus |

## Verification
Writes are committed on the rising edge that presents the address. Their effect can be seen only through a later read cycle. Read data and the drive flag are due one nanosecond after the edge that registers the read address, in the same cycle. The bench drives every input on the falling edge and samples one nanosecond after the next rising edge. The output enable is also toggled in the middle of a cycle, and the output is sampled one nanosecond later, so its asynchronous path is checked with no clock edge in between.

// File: rtl/sbsram_pkg.sv
// Package: shared types for the synchronous burst SRAM bank.
// Assumes nothing beyond IEEE 1800-2017 enums.
package sbsram_pkg;

    // Source of the address used in the current access cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,  // no access: idle or deselected
        SRC_EXT  = 2'd1,  // newly registered external address
        SRC_NEXT = 2'd2,  // burst advance
        SRC_CUR  = 2'd3   // burst suspend
    } addr_src_e;

endpackage

// File: rtl/sbsram_wmask.sv
// Module: write lane selection.
// Turns global write, byte-write mode enable and per-lane enables into a
// lane mask, using a three-level priority.
// Assumes all inputs are active low and stable around the clock edge.
module sbsram_wmask #(
    parameter int LANES = 8
) (
    input  logic             gwrite_n,
    input  logic             bwmode_n,
    input  logic [LANES-1:0] lane_we_n,
    output logic [LANES-1:0] lane_mask,
    output logic             wr_any
);

    // Priority: global write, then byte mode, then the per-lane enables.
    always_comb begin
        if (!gwrite_n) begin
            lane_mask = '1;
        end else if (!bwmode_n) begin
            lane_mask = ~lane_we_n;
        end else begin
            lane_mask = '0;
        end
    end

    // A cycle counts as a write only if at least one lane is stored.
    assign wr_any = |lane_mask;

endmodule

// File: rtl/sbsram_decode.sv
// Module: cycle decoder and burst address register.
// Classifies each rising edge as deselect, processor start, controller
// start, continue, suspend or idle. It gives the address used on this
// edge (for writes) and holds the registered address and read state (for
// flow-through reads).
// Assumes ADDR_W >= BURST_W; the burst counter wraps in the low BURST_W bits.
module sbsram_decode
    import sbsram_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              advance_n,
    input  logic              bank_en_n,
    input  logic              wr_any,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              do_write,
    output logic [ADDR_W-1:0] cur_addr_q,
    output logic              rd_q,
    output logic              active_q
);

    localparam int HI_W = ADDR_W - BURST_W;

    logic      desel;
    logic      proc_go;
    logic      ctrl_go;
    logic      cont;
    addr_src_e src;
    logic [ADDR_W-1:0] next_addr;

    // Decode the kind of cycle from the strobes and the bank enable.
    always_comb begin
        desel   = bank_en_n & ~ctrl_strobe_n;
        proc_go = ~bank_en_n & ~proc_strobe_n;
        ctrl_go = ~bank_en_n & ~ctrl_strobe_n & ~proc_go;
        cont    = ~desel & ~proc_go & ~ctrl_go & active_q;
    end

    // Next burst address: the low bits count up with wrap, the high bits stay.
    generate
        if (HI_W > 0) begin : g_hi
            assign next_addr = {cur_addr_q[ADDR_W-1:BURST_W],
                                BURST_W'(cur_addr_q[BURST_W-1:0] + 1'b1)};
        end else begin : g_flat
            assign next_addr = BURST_W'(cur_addr_q + 1'b1);
        end
    endgenerate

    // Pick the address source and the address used for this access.
    always_comb begin
        if (proc_go || ctrl_go) begin
            src = SRC_EXT;
        end else if (cont) begin
            src = advance_n ? SRC_CUR : SRC_NEXT;
        end else begin
            src = SRC_NONE;
        end
        case (src)
            SRC_EXT:  acc_addr = addr;
            SRC_NEXT: acc_addr = next_addr;
            default:  acc_addr = cur_addr_q;
        endcase
    end

    // Processor-strobe cycles never write; every other access follows the mask.
    assign do_write = (ctrl_go | cont) & wr_any;

    // Register the access address and the read state of the cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_q <= '0;
            rd_q       <= 1'b0;
            active_q   <= 1'b0;
        end else if (src != SRC_NONE) begin
            cur_addr_q <= acc_addr;
            rd_q       <= ~do_write;
            active_q   <= 1'b1;
        end else begin
            rd_q       <= 1'b0;
            active_q   <= 1'b0;
        end
    end

    // R5: a deselect ends the burst and the read state.
    p_desel_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> (!active_q && !rd_q));

    // R3: a processor strobe registers the address and reads.
    p_proc_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        proc_go |=> (rd_q && cur_addr_q == $past(addr)));

    // R7: a suspend keeps the address.
    p_suspend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && advance_n) |=> $stable(cur_addr_q));

    // R6: an advance steps the low bits by one.
    p_advance_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cont && !advance_n) |=>
            (cur_addr_q[BURST_W-1:0] == BURST_W'($past(cur_addr_q[BURST_W-1:0]) + 1'b1)));

endmodule

// File: rtl/sbsram_store.sv
// Module: lane-sliced storage array.
// One memory per byte lane holds 8 data bits plus one parity bit. A write
// stores only the selected lanes at the write address. The read port is
// asynchronous, which gives flow-through reads.
// Assumes DEPTH is small enough to model as flops.
module sbsram_store #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W,
    localparam int WORD_W = DATA_W + LANES
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  lane_mask,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            logic [LANE_W:0] mem [DEPTH];
            logic [LANE_W:0] rd_word;

            // Store this lane's data and parity when it is selected.
            always_ff @(posedge clk) begin
                if (we && lane_mask[k]) begin
                    mem[waddr] <= {wdata[DATA_W + k], wdata[k*LANE_W +: LANE_W]};
                end
            end

            // Flow-through read of this lane.
            assign rd_word = mem[raddr];
            assign rdata[k*LANE_W +: LANE_W] = rd_word[LANE_W-1:0];
            assign rdata[DATA_W + k]         = rd_word[LANE_W];
        end
    endgenerate

endmodule

// File: rtl/sbsram_bank.sv
// Module: top of the synchronous burst SRAM bank.
// Joins the write-mask decode, the cycle decoder and the storage. The
// output drive is gated by the registered read state and the asynchronous
// output enable.
// Assumes the host resolves the drive flag onto a shared bus.
module sbsram_bank #(
    parameter int ADDR_W  = 4,
    parameter int LANES   = 8,
    parameter int LANE_W  = 8,
    parameter int BURST_W = 2,
    localparam int WORD_W = LANES * LANE_W + LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              advance_n,
    input  logic              bank_en_n,
    input  logic              gwrite_n,
    input  logic              bwmode_n,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_drive
);

    logic [LANES-1:0]  lane_mask;
    logic              wr_any;
    logic [ADDR_W-1:0] acc_addr;
    logic              do_write;
    logic [ADDR_W-1:0] cur_addr_q;
    logic              rd_q;
    logic              active_q;

    sbsram_wmask #(.LANES(LANES)) u_wmask (
        .gwrite_n  (gwrite_n),
        .bwmode_n  (bwmode_n),
        .lane_we_n (lane_we_n),
        .lane_mask (lane_mask),
        .wr_any    (wr_any)
    );

    sbsram_decode #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_decode (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr          (addr),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .advance_n     (advance_n),
        .bank_en_n     (bank_en_n),
        .wr_any        (wr_any),
        .acc_addr      (acc_addr),
        .do_write      (do_write),
        .cur_addr_q    (cur_addr_q),
        .rd_q          (rd_q),
        .active_q      (active_q)
    );

    sbsram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk       (clk),
        .we        (do_write),
        .lane_mask (lane_mask),
        .waddr     (acc_addr),
        .wdata     (wdata),
        .raddr     (cur_addr_q),
        .rdata     (rdata)
    );

    // Drive only in a read cycle while the asynchronous enable is low.
    assign rdata_drive = rd_q & ~oe_n;

    // R10: the cycle after a write edge is never driven.
    p_write_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        do_write |=> !rdata_drive);

    // R11: out of reset there is no burst and no drive.
    p_reset_idle_r11: assert property (@(posedge clk)
        !rst_n |=> (!active_q && !rdata_drive));

endmodule

// File: tb/sbsram_bank_tb.sv
// Bench for sbsram_bank. A reference model built from the requirements
// predicts the address, the drive flag and the read data of every cycle.
module sbsram_bank_tb;

    localparam int AW = 4;
    localparam int WW = 72;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          sp_n = 1'b1, sc_n = 1'b1, adv_n = 1'b1, en_n = 1'b1;
    logic          gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b1;
    logic [7:0]    bw_n = 8'hFF;
    logic [WW-1:0] wdata = '0;
    logic [WW-1:0] rdata;
    logic          rdata_drive;

    int n_chk = 0;
    int n_bad = 0;

    logic [WW-1:0] ref_mem [16];
    logic [AW-1:0] m_cur = '0;
    logic          m_act = 1'b0;
    logic          m_rd  = 1'b0;

    always #2.5 clk = ~clk;

    sbsram_bank u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .proc_strobe_n(sp_n), .ctrl_strobe_n(sc_n), .advance_n(adv_n),
        .bank_en_n(en_n), .gwrite_n(gw_n), .bwmode_n(bwe_n),
        .lane_we_n(bw_n), .oe_n(oe_n), .wdata(wdata),
        .rdata(rdata), .rdata_drive(rdata_drive)
    );

    function automatic logic [WW-1:0] pat(int s);
        logic [31:0] a = 32'(s) * 32'd2654435761;
        logic [31:0] b = ~(32'(s) * 32'd40503);
        return {8'(s * 37 + 5), a, b};
    endfunction

    function automatic logic [WW-1:0] lane_bits(logic [7:0] m);
        logic [WW-1:0] r = '0;
        for (int k = 0; k < 8; k++) begin
            if (m[k]) begin
                r[k*8 +: 8] = 8'hFF;
                r[64 + k]   = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic check(string tag, logic exp_drv, logic [WW-1:0] exp_dat);
        n_chk++;
        if (rdata_drive !== exp_drv) begin
            n_bad++;
            $display("FAIL %s drive actual=%b expected=%b", tag, rdata_drive, exp_drv);
        end else if (exp_drv && rdata !== exp_dat) begin
            n_bad++;
            $display("FAIL %s data actual=%h expected=%h", tag, rdata, exp_dat);
        end
    endtask

    // One clock: drive on the falling edge, update the model, check 1 ns after the rising edge.
    task automatic step(string tag, logic i_sp, logic i_sc, logic i_adv, logic i_en,
                        logic i_gw, logic i_bwe, logic [7:0] i_bw, logic i_oe,
                        logic [AW-1:0] i_a, logic [WW-1:0] i_d);
        logic [7:0] m;
        logic       acc;
        @(negedge clk);
        sp_n = i_sp; sc_n = i_sc; adv_n = i_adv; en_n = i_en;
        gw_n = i_gw; bwe_n = i_bwe; bw_n = i_bw; oe_n = i_oe;
        addr = i_a; wdata = i_d;
        m   = !i_gw ? 8'hFF : (!i_bwe ? ~i_bw : 8'h00);
        acc = 1'b1;
        if (i_en && !i_sc) begin
            m_act = 1'b0; m_rd = 1'b0; acc = 1'b0;
        end else if (!i_en && !i_sp) begin
            m_cur = i_a; m_act = 1'b1; m = 8'h00;
        end else if (!i_en && !i_sc) begin
            m_cur = i_a; m_act = 1'b1;
        end else if (m_act) begin
            if (!i_adv) m_cur = {m_cur[3:2], 2'(m_cur[1:0] + 2'd1)};
        end else begin
            m_rd = 1'b0; acc = 1'b0;
        end
        if (acc) begin
            if (m != 8'h00) begin
                ref_mem[m_cur] = (ref_mem[m_cur] & ~lane_bits(m)) | (i_d & lane_bits(m));
                m_rd = 1'b0;
            end else begin
                m_rd = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        check(tag, m_rd && !i_oe, ref_mem[m_cur]);
    endtask

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) ref_mem[i] = '0;
        // R11: drive controls during reset, then check idle state
        repeat (3) @(negedge clk);
        sc_n = 1'b0; en_n = 1'b0; oe_n = 1'b0;
        @(posedge clk); #1;
        check("R11 in reset", 1'b0, '0);
        @(negedge clk);
        rst_n = 1'b1; sc_n = 1'b1; en_n = 1'b1;
        @(posedge clk); #1;
        check("R11 after reset", 1'b0, '0);

        // R12/R1/R10: synchronous-only full-word writes, byte mode off
        for (int a = 0; a < 16; a++)
            step("R12 R1 R10 sync write", 1, 0, 1, 0, 0, 1, 8'h5A, 0, 4'(a), pat(a));
        // R12/R8: synchronous-only reads, every address
        for (int a = 0; a < 16; a++)
            step("R12 R8 sync read", 1, 0, 1, 0, 1, 1, 8'hFF, 0, 4'(a), '0);

        // R2/R3: sweep every lane-enable pattern, then read back with a processor strobe
        for (int m = 0; m < 256; m++) begin
            step("R2 R4 masked write", 1, 0, 1, 0, 1, 0, ~8'(m), 0, 4'(m % 16), pat(1000 + m));
            step("R3 R2 proc read", 0, 1, 1, 0, 0, 0, 8'h00, 0, 4'(m % 16), pat(7));
        end
        // R2: byte mode off with lanes enabled is a read
        step("R2 no byte mode", 1, 0, 1, 0, 1, 1, 8'h00, 0, 4'd3, pat(9));
        // R1: global write ignores byte mode and lane enables
        step("R1 global write", 1, 0, 1, 0, 0, 0, 8'hFF, 0, 4'd3, pat(77));
        step("R1 readback", 0, 1, 1, 0, 1, 1, 8'hFF, 0, 4'd3, '0);

        // R4/R6: write burst 9,10,11,8 then read burst
        step("R4 burst write start", 1, 0, 1, 0, 0, 1, 8'hFF, 0, 4'd9, pat(201));
        for (int i = 0; i < 3; i++)
            step("R6 burst write advance", 1, 1, 0, 1, 0, 1, 8'hFF, 0, 4'd0, pat(202 + i));
        step("R4 burst read start", 1, 0, 1, 0, 1, 1, 8'hFF, 0, 4'd9, '0);
        for (int i = 0; i < 4; i++)
            step("R6 burst read advance wrap", 1, 1, 0, 1, 1, 1, 8'hFF, 0, 4'd0, '0);
        // R7: suspend keeps the address for reads and writes
        step("R7 suspend read", 1, 1, 1, 1, 1, 1, 8'hFF, 0, 4'd2, '0);
        step("R7 suspend write", 1, 1, 1, 1, 1, 0, 8'hF0, 0, 4'd2, pat(300));
        step("R7 suspend readback", 1, 1, 1, 1, 1, 1, 8'hFF, 0, 4'd2, '0);

        // R5: deselect, then advance cycles with write requests are ignored
        step("R5 deselect", 1, 0, 1, 1, 1, 1, 8'hFF, 0, 4'd9, '0);
        for (int i = 0; i < 3; i++)
            step("R5 ignored advance", 1, 1, 0, 1, 0, 1, 8'hFF, 0, 4'd0, pat(400 + i));
        step("R5 ignored proc strobe disabled", 0, 1, 0, 1, 0, 1, 8'hFF, 0, 4'd9, pat(409));
        for (int a = 8; a < 12; a++)
            step("R5 memory unchanged", 0, 1, 1, 0, 1, 1, 8'hFF, 0, 4'(a), '0);

        // R9: read with enable high, then lower it mid-cycle
        step("R9 oe high no drive", 0, 1, 1, 0, 1, 1, 8'hFF, 1, 4'd5, '0);
        @(negedge clk); oe_n = 1'b0; #1;
        check("R9 async oe low", 1'b1, ref_mem[5]);
        #0.5 oe_n = 1'b1; #0.5;
        check("R9 async oe high", 1'b0, '0);
        // R10: write cycle with output enable low stays undriven
        step("R10 write quiet", 1, 0, 1, 0, 0, 1, 8'hFF, 0, 4'd5, pat(500));
        step("R8 R10 readback", 0, 1, 1, 0, 1, 1, 8'hFF, 0, 4'd5, '0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule